// File: doc/BRIEF.md
# Scatter Segment Descriptor Generator

This block turns a stream of memory segments, each given as a base address and a byte length, into a stream of fixed-format hardware descriptors for a circular descriptor ring. A segment longer than the per-descriptor limit of 32760 bytes is cut into consecutive full-size chunks followed by one remainder chunk. Segments are grouped into batches: a batch ends with the segment that carries the end mark, and that segment also carries the batch options (completion interrupt wanted, fence wanted).

The block keeps the ring tail index and tags every descriptor with the slot it belongs in. The ring holds 4095 usable slots, so the tail wraps from 4094 back to 0. No more than 4095 descriptors go out between doorbells. When a batch needs more, the 4095th descriptor is given an interrupt request and a doorbell is raised so that the rest can be issued as a further run. A doorbell pulse carries the new tail as a byte offset, which is the tail multiplied by the 8-byte descriptor size. The byte total of each batch is reported so that software can track the residue. Writing the ring memory is left to the consumer of the descriptor stream.

Top module: `sgd_desc_gen`

## Requirements
- R1: After reset, no descriptor, doorbell or batch report is valid, the segment input is ready, and the first descriptor issued goes to slot 0.
- R2: A segment of length L produces ceil(L/32760) descriptors. Every chunk except the last has size 32760, and the last holds the remainder. Chunk k has address base + k*32760.
- R3: A segment of length zero is accepted and produces no descriptor.
- R4: Each accepted descriptor takes the current tail slot, and the tail then advances by one, wrapping from 4094 to 0.
- R5: The final descriptor of a batch has flag bit 14 (end of transfer) set if a completion interrupt was requested, and flag bit 15 (interrupt) set otherwise. Flag bit 12 (notify when done) is also set if a fence was requested. All other flag bits are zero.
- R6: A descriptor that is neither the last of its batch nor the 4095th since the previous doorbell has all flag bits zero.
- R7: When 4095 descriptors have gone out since the previous doorbell and the 4095th is not the end of its batch, that descriptor carries flag bit 15 only and ends the current issue run.
- R8: One cycle after the handshake of a descriptor that ends a batch or an issue run, a doorbell pulses for one cycle with offset equal to the new tail times 8. A zero-length segment carrying the end mark rings the doorbell with the unchanged tail and starts a fresh issue run.
- R9: One cycle after the segment with the end mark is accepted, a batch report pulses with the sum of all segment lengths of that batch.
- R10: While the descriptor output is valid and not ready, its address and size stay stable. No new segment is accepted while a segment is still being split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment can be accepted |
| seg_addr | input | 32 | Segment base address |
| seg_len | input | 20 | Segment length in bytes |
| seg_end | input | 1 | Segment closes its batch |
| seg_cmpl_irq | input | 1 | Batch wants a completion interrupt (read with end mark) |
| seg_fence | input | 1 | Batch wants notify-when-done (read with end mark) |
| dsc_valid | output | 1 | Descriptor offered |
| dsc_ready | input | 1 | Descriptor consumer ready |
| dsc_addr | output | 32 | Chunk address |
| dsc_size | output | 16 | Chunk size in bytes |
| dsc_flags | output | 16 | Descriptor flags (bit 15 interrupt, bit 14 end of transfer, bit 12 notify when done) |
| dsc_slot | output | 12 | Ring slot of this descriptor |
| db_valid | output | 1 | Doorbell pulse |
| db_offset | output | 15 | New tail in bytes |
| bt_valid | output | 1 | Batch total pulse |
| bt_bytes | output | 32 | Byte total of the batch |

## Verification
Two events can land in the same cycle. In the first, the 4095th descriptor of an issue run is also the last of its batch, so the end-of-batch flags and the run-full interrupt compete for one descriptor. In the second, a run-full doorbell is followed directly by a batch-end doorbell, and the last segment's batch report overlaps the splitting of that same segment. A batch of 130 maximum-length segments (4160 descriptors) drives the issue counter through its limit while the tail wraps. The behavioural model predicts, in each cycle, every descriptor field, the flag choice made for that slot, and the exact cycle and value of each doorbell and report. Stalls on the descriptor output come from a pseudo-random ready pattern.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

  // Flag bit positions decoded by the ring consumer.
  localparam int FLG_INT_BIT = 15;
  localparam int FLG_EOT_BIT = 14;
  localparam int FLG_NWD_BIT = 12;

  typedef logic [15:0] dflags_t;

  // Role a descriptor plays in its issue run.
  typedef enum logic [1:0] {
    ROLE_PLAIN = 2'd0,
    ROLE_FILL  = 2'd1,
    ROLE_LAST  = 2'd2
  } role_e;

  // Flags for a descriptor of the given role.
  function automatic dflags_t role_flags(input role_e role, input logic cmpl, input logic fence);
    dflags_t f;
    f = '0;
    case (role)
      ROLE_LAST: begin
        if (cmpl) f[FLG_EOT_BIT] = 1'b1;
        else      f[FLG_INT_BIT] = 1'b1;
        f[FLG_NWD_BIT] = fence;
      end
      ROLE_FILL: f[FLG_INT_BIT] = 1'b1;
      default:   f = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/sgd_splitter.sv
module sgd_splitter #(
  parameter int AW        = 32,
  parameter int LW        = 20,
  parameter int SZW       = 16,
  parameter int MAX_CHUNK = 32760
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [LW-1:0] in_len,
  input  logic          in_end,
  input  logic          in_cmpl,
  input  logic          in_fence,
  output logic          in_take,
  output logic          zero_end,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [SZW-1:0] out_size,
  output logic          out_batch_end,
  output logic          out_cmpl,
  output logic          out_fence
);

  localparam logic [LW-1:0] MAXL = LW'(MAX_CHUNK);
  localparam logic [AW-1:0] STEP = AW'(MAX_CHUNK);

  logic          busy;
  logic [AW-1:0] cur_addr;
  logic [LW-1:0] rem_len;
  logic          cur_end, cur_cmpl, cur_fence;
  logic          last_chunk;
  logic          out_fire;

  function automatic logic [SZW-1:0] fit_size(input logic [LW-1:0] r);
    if (r > MAXL) return SZW'(MAX_CHUNK);
    return r[SZW-1:0];
  endfunction

  assign in_ready      = !busy;
  assign in_take       = in_valid && in_ready;
  assign zero_end      = in_take && (in_len == '0) && in_end;
  assign last_chunk    = (rem_len <= MAXL);
  assign out_valid     = busy;
  assign out_fire      = busy && out_ready;
  assign out_addr      = cur_addr;
  assign out_size      = fit_size(rem_len);
  assign out_batch_end = last_chunk && cur_end;
  assign out_cmpl      = cur_cmpl;
  assign out_fence     = cur_fence;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cur_addr  <= '0;
      rem_len   <= '0;
      cur_end   <= 1'b0;
      cur_cmpl  <= 1'b0;
      cur_fence <= 1'b0;
    end else if (in_take && (in_len != '0)) begin
      busy      <= 1'b1;
      cur_addr  <= in_addr;
      rem_len   <= in_len;
      cur_end   <= in_end;
      cur_cmpl  <= in_cmpl;
      cur_fence <= in_fence;
    end else if (out_fire) begin
      if (last_chunk) begin
        busy <= 1'b0;
      end else begin
        cur_addr <= cur_addr + STEP;
        rem_len  <= rem_len - MAXL;
      end
    end
  end

  // R10: a stalled descriptor keeps its contents
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_size)));

  // R10: no segment is taken while one is being split
  a_r10_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R2 / R3: every emitted chunk is non-empty and within the limit
  a_r2_size_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_size != '0) && (out_size <= SZW'(MAX_CHUNK)));

endmodule

// File: rtl/sgd_ring_tail.sv
module sgd_ring_tail
  import sgd_pkg::*;
#(
  parameter int SLOTS      = 4095,
  parameter int DESC_BYTES = 8,
  localparam int TW        = $clog2(SLOTS),
  localparam int DSH       = $clog2(DESC_BYTES),
  localparam int OFFW      = TW + DSH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            batch_end,
  input  logic            zero_end,
  output logic [TW-1:0]   slot,
  output role_e           role,
  output logic            db_valid,
  output logic [OFFW-1:0] db_offset
);

  localparam logic [TW-1:0] TOP = TW'(SLOTS - 1);

  logic [TW-1:0] tail, tail_nx, issue_cnt, ring_pos;
  logic          fill_hit;

  function automatic logic [TW-1:0] wrap_inc(input logic [TW-1:0] v);
    return (v == TOP) ? '0 : v + 1'b1;
  endfunction

  assign fill_hit = (issue_cnt == TOP);
  assign role     = batch_end ? ROLE_LAST : (fill_hit ? ROLE_FILL : ROLE_PLAIN);
  assign tail_nx  = wrap_inc(tail);
  assign slot     = tail;
  assign ring_pos = fire ? tail_nx : tail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail      <= '0;
      issue_cnt <= '0;
      db_valid  <= 1'b0;
      db_offset <= '0;
    end else begin
      db_valid  <= (fire && (role != ROLE_PLAIN)) || zero_end;
      db_offset <= {ring_pos, {DSH{1'b0}}};
      if (fire) begin
        tail      <= tail_nx;
        issue_cnt <= (role != ROLE_PLAIN) ? '0 : issue_cnt + 1'b1;
      end else if (zero_end) begin
        issue_cnt <= '0;
      end
    end
  end

  // R4: the tail index stays inside the ring
  a_r4_tail_range: assert property (@(posedge clk) disable iff (!rst_n)
    tail <= TOP);

  // R4: the tail moves only when a descriptor is taken
  a_r4_tail_still: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(slot));

  // R7: an issue run never exceeds the ring capacity
  a_r7_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    issue_cnt <= TOP);

  // R8: a doorbell always has a cause in the previous cycle
  a_r8_db_cause: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid |-> $past(fire || zero_end));

endmodule

// File: rtl/sgd_batch_sum.sv
module sgd_batch_sum #(
  parameter int LW   = 20,
  parameter int TOTW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [LW-1:0]   len,
  input  logic            last,
  output logic            bt_valid,
  output logic [TOTW-1:0] bt_bytes
);

  logic [TOTW-1:0] acc, acc_nx;

  assign acc_nx = acc + TOTW'(len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      bt_valid <= 1'b0;
      bt_bytes <= '0;
    end else begin
      bt_valid <= take && last;
      if (take) begin
        if (last) begin
          bt_bytes <= acc_nx;
          acc      <= '0;
        end else begin
          acc <= acc_nx;
        end
      end
    end
  end

  // R9: a batch report follows the acceptance of an end-marked segment
  a_r9_report_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bt_valid |-> $past(take && last));

endmodule

// File: rtl/sgd_desc_gen.sv
module sgd_desc_gen
  import sgd_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LW         = 20,
  parameter int SZW        = 16,
  parameter int MAX_CHUNK  = 32760,
  parameter int SLOTS      = 4095,
  parameter int DESC_BYTES = 8,
  parameter int TOTW       = 32,
  localparam int TW        = $clog2(SLOTS),
  localparam int OFFW      = TW + $clog2(DESC_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seg_valid,
  output logic            seg_ready,
  input  logic [AW-1:0]   seg_addr,
  input  logic [LW-1:0]   seg_len,
  input  logic            seg_end,
  input  logic            seg_cmpl_irq,
  input  logic            seg_fence,
  output logic            dsc_valid,
  input  logic            dsc_ready,
  output logic [AW-1:0]   dsc_addr,
  output logic [SZW-1:0]  dsc_size,
  output logic [15:0]     dsc_flags,
  output logic [TW-1:0]   dsc_slot,
  output logic            db_valid,
  output logic [OFFW-1:0] db_offset,
  output logic            bt_valid,
  output logic [TOTW-1:0] bt_bytes
);

  logic  seg_take, zero_end, batch_end, cmpl, fence, fire;
  role_e role;

  sgd_splitter #(.AW(AW), .LW(LW), .SZW(SZW), .MAX_CHUNK(MAX_CHUNK)) i_split (
    .clk(clk), .rst_n(rst_n),
    .in_valid(seg_valid), .in_ready(seg_ready), .in_addr(seg_addr), .in_len(seg_len),
    .in_end(seg_end), .in_cmpl(seg_cmpl_irq), .in_fence(seg_fence),
    .in_take(seg_take), .zero_end(zero_end),
    .out_valid(dsc_valid), .out_ready(dsc_ready), .out_addr(dsc_addr), .out_size(dsc_size),
    .out_batch_end(batch_end), .out_cmpl(cmpl), .out_fence(fence)
  );

  assign fire = dsc_valid && dsc_ready;

  sgd_ring_tail #(.SLOTS(SLOTS), .DESC_BYTES(DESC_BYTES)) i_tail (
    .clk(clk), .rst_n(rst_n), .fire(fire), .batch_end(batch_end), .zero_end(zero_end),
    .slot(dsc_slot), .role(role), .db_valid(db_valid), .db_offset(db_offset)
  );

  sgd_batch_sum #(.LW(LW), .TOTW(TOTW)) i_sum (
    .clk(clk), .rst_n(rst_n), .take(seg_take), .len(seg_len), .last(seg_end),
    .bt_valid(bt_valid), .bt_bytes(bt_bytes)
  );

  assign dsc_flags = role_flags(role, cmpl, fence);

  // R5 / R6 / R7: only the defined flag bits appear, never both interrupt kinds
  a_r5_flag_space: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid |-> ((dsc_flags & 16'h2FFF) == 16'h0) &&
                  !(dsc_flags[FLG_INT_BIT] && dsc_flags[FLG_EOT_BIT]));

  // R8: notify-when-done appears only together with a batch end flag
  a_r8_nwd_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_valid && dsc_flags[FLG_NWD_BIT]) |-> (dsc_flags[FLG_INT_BIT] || dsc_flags[FLG_EOT_BIT]));

endmodule

// File: tb/test_sgd_desc_gen.sv
module test_sgd_desc_gen;

  localparam longint MAXC  = 32760;
  localparam int     SLOTS = 4095;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        seg_valid, seg_ready, seg_end, seg_cmpl_irq, seg_fence;
  logic [31:0] seg_addr;
  logic [19:0] seg_len;
  logic        dsc_valid, dsc_ready;
  logic [31:0] dsc_addr;
  logic [15:0] dsc_size, dsc_flags;
  logic [11:0] dsc_slot;
  logic        db_valid, bt_valid;
  logic [14:0] db_offset;
  logic [31:0] bt_bytes;

  always #10 clk = ~clk;

  sgd_desc_gen i_sgd_desc_gen (
    .clk(clk), .rst_n(rst_n),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
    .seg_end(seg_end), .seg_cmpl_irq(seg_cmpl_irq), .seg_fence(seg_fence),
    .dsc_valid(dsc_valid), .dsc_ready(dsc_ready), .dsc_addr(dsc_addr), .dsc_size(dsc_size),
    .dsc_flags(dsc_flags), .dsc_slot(dsc_slot),
    .db_valid(db_valid), .db_offset(db_offset), .bt_valid(bt_valid), .bt_bytes(bt_bytes)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model state
  typedef struct {
    longint base;
    longint rem;
    longint off;
    bit     fin;
    bit     cmpl;
    bit     fence;
  } mseg_t;

  mseg_t  q[$];
  int     tail_m  = 0;
  int     issue_m = 0;
  bit     db_due  = 0;
  longint db_exp  = 0;
  bit     bt_due  = 0;
  longint bt_exp  = 0;
  longint acc_m   = 0;
  bit     mon_on  = 0;
  bit     bp      = 0;
  logic [15:0] lfsr = 16'hACE1;

  // Ready pattern on the descriptor output
  initial begin
    dsc_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      dsc_ready = bp ? lfsr[0] : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
  end

  // Per-cycle comparison against the model
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        chk("R10 seg_ready", seg_ready, q.size() == 0);
        chk("R2/R3 dsc_valid", dsc_valid, q.size() != 0);
        chk("R8 db_valid", db_valid, db_due);
        if (db_due) chk("R8 db_offset", db_offset, db_exp);
        chk("R9 bt_valid", bt_valid, bt_due);
        if (bt_due) chk("R9 bt_bytes", bt_bytes, bt_exp);
        db_due = 0;
        bt_due = 0;
        if (dsc_valid && dsc_ready && q.size() != 0) begin
          mseg_t  h;
          longint sz;
          bit     lastc, bend, fill;
          longint fl;
          h     = q[0];
          lastc = (h.rem <= MAXC);
          sz    = lastc ? h.rem : MAXC;
          bend  = lastc && h.fin;
          fill  = (issue_m == SLOTS - 1);
          if (bend)      fl = (h.cmpl ? 'h4000 : 'h8000) | (h.fence ? 'h1000 : 0);
          else if (fill) fl = 'h8000;
          else           fl = 0;
          chk("R2 dsc_addr", dsc_addr, (h.base + h.off) & 64'hFFFF_FFFF);
          chk("R2 dsc_size", dsc_size, sz);
          if (bend)      chk("R5 dsc_flags", dsc_flags, fl);
          else if (fill) chk("R7 dsc_flags", dsc_flags, fl);
          else           chk("R6 dsc_flags", dsc_flags, fl);
          chk("R4 dsc_slot", dsc_slot, tail_m);
          tail_m = (tail_m + 1) % SLOTS;
          if (bend || fill) begin
            issue_m = 0;
            db_due  = 1;
            db_exp  = tail_m * 8;
          end else begin
            issue_m++;
          end
          if (lastc) void'(q.pop_front());
          else begin
            h.rem -= MAXC;
            h.off += MAXC;
            q[0] = h;
          end
        end
        if (seg_valid && seg_ready) begin
          if (seg_end) begin
            bt_due = 1;
            bt_exp = acc_m + seg_len;
            acc_m  = 0;
          end else begin
            acc_m += seg_len;
          end
          if (seg_len != 0) begin
            q.push_back('{base: seg_addr, rem: seg_len, off: 0, fin: seg_end,
                          cmpl: seg_cmpl_irq, fence: seg_fence});
          end else if (seg_end) begin
            // R3 / R8: no descriptor, doorbell at unchanged tail
            db_due  = 1;
            db_exp  = tail_m * 8;
            issue_m = 0;
          end
        end
      end
    end
  end

  task automatic send(input longint a, input longint l, input bit e, input bit c, input bit f);
    @(posedge clk);
    #1;
    seg_valid    = 1'b1;
    seg_addr     = a[31:0];
    seg_len      = l[19:0];
    seg_end      = e;
    seg_cmpl_irq = c;
    seg_fence    = f;
    do @(negedge clk); while (!seg_ready);
    @(posedge clk);
    #1;
    seg_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0);
    repeat (4) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (180000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n        = 1'b0;
    seg_valid    = 1'b0;
    seg_addr     = '0;
    seg_len      = '0;
    seg_end      = 1'b0;
    seg_cmpl_irq = 1'b0;
    seg_fence    = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 dsc_valid", dsc_valid, 0);
    chk("R1 db_valid", db_valid, 0);
    chk("R1 bt_valid", bt_valid, 0);
    chk("R1 seg_ready", seg_ready, 1);
    @(posedge clk);
    #1;
    rst_n  = 1'b1;
    mon_on = 1;

    // R2 / R5: below, at and just over the chunk limit, completion interrupt
    send(32'h1000, 100, 0, 0, 0);
    send(32'h2000, 32760, 0, 0, 0);
    send(32'h3000, 32761, 1, 1, 0);
    wait_idle();

    // R2 / R5: four-chunk segment, no completion interrupt, fence
    send(32'h0010_0000, 100000, 1, 0, 1);
    wait_idle();

    // R3 / R8: zero-length segments in a batch and as its end
    send(32'h5000, 0, 0, 0, 0);
    send(32'h6000, 40, 0, 0, 0);
    send(32'h7000, 0, 1, 1, 1);
    wait_idle();
    send(32'h8000, 0, 1, 0, 0);
    wait_idle();

    // R10: stalls on the descriptor output
    bp = 1;
    send(32'h9000, 70000, 0, 0, 0);
    send(32'hA000, 5, 1, 1, 1);
    wait_idle();
    bp = 0;

    // R4 / R7: long batch crosses the run limit and wraps the tail
    for (int i = 0; i < 130; i++)
      send(64'h4000_0000 + i * 64'h10_0000, 1048320, i == 129, 1, 0);
    wait_idle();

    // R4: the tail keeps counting after the wrap
    bp = 1;
    send(32'hB000, 10, 1, 0, 0);
    wait_idle();
    bp = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule